// File: doc/BRIEF.md
# Prioritized Bus Request Queue

This block sits between a processor's two first-level caches and a single system bus port. The instruction cache hands it fetch requests. The data cache hands it loads, stores, castouts, touch loads, load-and-reserve operations and conditional stores. Each request carries a physical address. Accepted requests wait in a small set of address slots until the bus takes them, and each slot stays occupied until the bus reports that its transaction has completed. Completions may arrive in any order.

A combinational picker chooses the next slot to issue. Loads come first, instruction fetches second, and stores and castouts last. Within a class, the oldest request wins. A load is held back only while an older store or castout to the same 32-byte line is still waiting.

Addresses snooped from the bus are latched and compared at line granularity against every occupied slot and against the held reservation. A snoop that matches the reservation clears it. A conditional store without a matching reservation is answered with a failure pulse and never reaches the bus. The block also keeps a register holding the address of the most recent touch load.

Top module: `bus_req_queue`

## Requirements
- R1: At most one request is accepted per cycle, and the data cache port wins a tie. `ic_ready` is low whenever `dc_valid` is high, and an instruction fetch is accepted only in a cycle where the data cache presents nothing.
- R2: The queue has four slots. A new request takes the lowest-numbered free slot, and that slot number is the `bus_tag` it later issues and completes under. When all four slots are occupied, both `dc_ready` and `ic_ready` are low.
- R3: `bus_op` is coded 0 for fetch, 1 for load, 2 for store and 3 for castout. Among waiting slots, a load issues before a fetch, and a fetch issues before a store or castout. Stores and castouts share a class. Within a class, the earliest accepted request goes first, whatever its slot number.
- R4: A waiting load is not offered to the bus while an older, not yet issued store or castout has the same address bits 31..5. A load to a different line may pass such a store.
- R5: A slot is offered on the bus once, on the cycle `bus_valid && bus_ready` is high. It stays occupied until `cmp_valid` names its tag, and completions free slots in any order.
- R6: A snoop strobe latches `snp_addr` at the clock edge. During the following cycle, bit i of `snp_hit` is high exactly when slot i is occupied and holds the same address bits 31..5.
- R7: `dc_op` 4 (load-and-reserve) queues a load and arms the reservation on that line. A snoop whose line equals the armed reservation raises `snp_rsv_hit` in the cycle after the strobe, and the reservation is cleared at the next edge.
- R8: `dc_op` 5 (conditional store) with an armed reservation on the same line queues a store (`bus_op` 2) and disarms the reservation. Otherwise the request occupies no slot and `stc_fail` is high for the one cycle after acceptance.
- R9: `dc_op` 0, 1 and 2 queue a load, a store and a castout. `dc_op` 3 (touch load) queues a load and loads `touch_addr` with its address, with `touch_valid` set from then on.
- R10: After reset all slots are free, both ready outputs are high, `bus_valid`, `snp_hit`, `snp_rsv_hit`, `stc_fail` and `touch_valid` are low, and no reservation is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ic_valid | input | 1 | Instruction fetch request present |
| ic_ready | output | 1 | Fetch request can be taken this cycle |
| ic_addr | input | 32 | Fetch physical address |
| dc_valid | input | 1 | Data cache request present |
| dc_ready | output | 1 | Data request can be taken this cycle |
| dc_op | input | 3 | Data request kind (0 load, 1 store, 2 castout, 3 touch, 4 load-reserve, 5 conditional store) |
| dc_addr | input | 32 | Data request physical address |
| bus_valid | output | 1 | A slot is offered to the bus |
| bus_ready | input | 1 | Bus takes the offered slot |
| bus_op | output | 2 | Offered transaction kind |
| bus_addr | output | 32 | Offered transaction address |
| bus_tag | output | 2 | Slot number of the offered transaction |
| cmp_valid | input | 1 | Bus completes a transaction |
| cmp_tag | input | 2 | Slot number being completed |
| snp_valid | input | 1 | Snoop address strobe |
| snp_addr | input | 32 | Snooped physical address |
| snp_hit | output | 4 | Per-slot snoop line match |
| snp_rsv_hit | output | 1 | Snoop matched the armed reservation |
| stc_fail | output | 1 | Conditional store failed without bus access |
| touch_valid | output | 1 | Touch-load register holds an address |
| touch_addr | output | 32 | Most recent touch-load address |

## Verification
The bench fills the queue with every traffic class and then drains it. If the picker ordered the classes wrongly, or chose by slot number instead of age, issue tags would come out in the wrong sequence. It places loads beside older stores to the same line and to a neighbouring line. A missing hazard would let the dependent load overtake the store, and an over-broad hazard would stall the unrelated load. It also checks that reservations behave correctly. A conditional store that went to the bus without a reservation, or after a snoop had cleared it, would show up as a missing failure pulse or as an unexpected issue. A reservation that is not consumed or cleared would let a second conditional store slip through.

// File: rtl/brq_pkg.sv
package brq_pkg;

    typedef enum logic [1:0] {
        K_FETCH = 2'd0,
        K_LOAD  = 2'd1,
        K_STORE = 2'd2,
        K_CAST  = 2'd3
    } kind_e;

    typedef enum logic [2:0] {
        D_LOAD   = 3'd0,
        D_STORE  = 3'd1,
        D_CAST   = 3'd2,
        D_TOUCH  = 3'd3,
        D_LDRSV  = 3'd4,
        D_STCOND = 3'd5
    } dop_e;

    // Issue class rank: larger rank is offered first
    function automatic logic [1:0] rank_of(kind_e k);
        case (k)
            K_LOAD:  return 2'd2;
            K_FETCH: return 2'd1;
            default: return 2'd0;
        endcase
    endfunction

    function automatic kind_e kind_of(dop_e d);
        case (d)
            D_STORE, D_STCOND: return K_STORE;
            D_CAST:            return K_CAST;
            default:           return K_LOAD;
        endcase
    endfunction

endpackage

// File: rtl/brq_arbiter.sv
module brq_arbiter
    import brq_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int LW    = 27,
    parameter int TW    = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] pend,
    input  kind_e            kind  [DEPTH],
    input  logic [LW-1:0]    line  [DEPTH],
    input  logic [DEPTH-1:0] older [DEPTH],
    output logic             grant_v,
    output logic [TW-1:0]    grant_idx
);

    logic [DEPTH-1:0] blocked;
    logic [DEPTH-1:0] elig;
    logic [DEPTH-1:0] win;

    always_comb begin
        // Loads wait behind older same-line writes
        for (int i = 0; i < DEPTH; i++) begin
            blocked[i] = 1'b0;
            if (kind[i] == K_LOAD) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (pend[j] && older[j][i] &&
                        (kind[j] == K_STORE || kind[j] == K_CAST) &&
                        line[j] == line[i])
                        blocked[i] = 1'b1;
                end
            end
        end
        elig = pend & ~blocked;

        for (int i = 0; i < DEPTH; i++) begin
            win[i] = elig[i];
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && elig[j]) begin
                    if (!(rank_of(kind[i]) > rank_of(kind[j]) ||
                          (rank_of(kind[i]) == rank_of(kind[j]) && older[i][j])))
                        win[i] = 1'b0;
                end
            end
        end

        grant_v   = |win;
        grant_idx = '0;
        for (int i = 0; i < DEPTH; i++)
            if (win[i]) grant_idx = TW'(i);

        AST_ONE_GRANT: assert ($onehot0(win)); // R3
    end

endmodule

// File: rtl/brq_snoop.sv
module brq_snoop #(
    parameter int DEPTH = 4,
    parameter int LW    = 27
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             snp_valid,
    input  logic [LW-1:0]    snp_line,
    input  logic [DEPTH-1:0] ent_vld,
    input  logic [LW-1:0]    ent_line [DEPTH],
    input  logic             rsv_v,
    input  logic [LW-1:0]    rsv_line,
    output logic [DEPTH-1:0] hit_vec,
    output logic             rsv_hit
);

    logic          snp_q;
    logic [LW-1:0] snp_line_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            snp_q      <= 1'b0;
            snp_line_q <= '0;
        end else begin
            snp_q      <= snp_valid;
            snp_line_q <= snp_line;
        end
    end

    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            hit_vec[i] = snp_q && ent_vld[i] && (ent_line[i] == snp_line_q);
        rsv_hit = snp_q && rsv_v && (rsv_line == snp_line_q);
    end

    AST_SNOOP_LATCHED: assert property (@(posedge clk) disable iff (rst)
        (|hit_vec || rsv_hit) |-> $past(snp_valid)); // R6

endmodule

// File: rtl/bus_req_queue.sv
module bus_req_queue
    import brq_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int AW        = 32,
    parameter int LINE_BITS = 5,
    parameter int TW        = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ic_valid,
    output logic             ic_ready,
    input  logic [AW-1:0]    ic_addr,
    input  logic             dc_valid,
    output logic             dc_ready,
    input  logic [2:0]       dc_op,
    input  logic [AW-1:0]    dc_addr,
    output logic             bus_valid,
    input  logic             bus_ready,
    output logic [1:0]       bus_op,
    output logic [AW-1:0]    bus_addr,
    output logic [TW-1:0]    bus_tag,
    input  logic             cmp_valid,
    input  logic [TW-1:0]    cmp_tag,
    input  logic             snp_valid,
    input  logic [AW-1:0]    snp_addr,
    output logic [DEPTH-1:0] snp_hit,
    output logic             snp_rsv_hit,
    output logic             stc_fail,
    output logic             touch_valid,
    output logic [AW-1:0]    touch_addr
);

    localparam int LW = AW - LINE_BITS;

    logic [DEPTH-1:0] vld, iss;
    kind_e            kind  [DEPTH];
    logic [AW-1:0]    addr  [DEPTH];
    logic [LW-1:0]    line  [DEPTH];
    logic [DEPTH-1:0] older [DEPTH];

    logic             rsv_v;
    logic [LW-1:0]    rsv_line;

    logic             has_free, dc_acc, ic_acc, rsv_match, enq, issue;
    logic [TW-1:0]    free_idx, grant_idx;
    logic             grant_v;
    kind_e            enq_kind;
    logic [AW-1:0]    enq_addr;
    dop_e             dop;

    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            line[i] = addr[i][AW-1:LINE_BITS];
        has_free = ~&vld;
        free_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--)
            if (!vld[i]) free_idx = TW'(i);
        dop       = dop_e'(dc_op);
        dc_ready  = has_free;
        ic_ready  = has_free && !dc_valid;
        dc_acc    = dc_valid && has_free;
        ic_acc    = ic_valid && ic_ready;
        rsv_match = rsv_v && (dc_addr[AW-1:LINE_BITS] == rsv_line);
        enq       = ic_acc || (dc_acc && (dop != D_STCOND || rsv_match));
        enq_kind  = ic_acc ? K_FETCH : kind_of(dop);
        enq_addr  = ic_acc ? ic_addr : dc_addr;
    end

    brq_arbiter #(.DEPTH(DEPTH), .LW(LW), .TW(TW)) i_arb (
        .pend      (vld & ~iss),
        .kind      (kind),
        .line      (line),
        .older     (older),
        .grant_v   (grant_v),
        .grant_idx (grant_idx)
    );

    brq_snoop #(.DEPTH(DEPTH), .LW(LW)) i_snp (
        .clk       (clk),
        .rst       (rst),
        .snp_valid (snp_valid),
        .snp_line  (snp_addr[AW-1:LINE_BITS]),
        .ent_vld   (vld),
        .ent_line  (line),
        .rsv_v     (rsv_v),
        .rsv_line  (rsv_line),
        .hit_vec   (snp_hit),
        .rsv_hit   (snp_rsv_hit)
    );

    assign bus_valid = grant_v;
    assign bus_tag   = grant_idx;
    assign bus_op    = kind[grant_idx];
    assign bus_addr  = addr[grant_idx];
    assign issue     = grant_v && bus_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld         <= '0;
            iss         <= '0;
            rsv_v       <= 1'b0;
            rsv_line    <= '0;
            stc_fail    <= 1'b0;
            touch_valid <= 1'b0;
            touch_addr  <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                kind[i]  <= K_FETCH;
                addr[i]  <= '0;
                older[i] <= '0;
            end
        end else begin
            stc_fail <= dc_acc && dop == D_STCOND && !rsv_match;
            if (issue)
                iss[grant_idx] <= 1'b1;
            if (cmp_valid) begin
                vld[cmp_tag] <= 1'b0;
                iss[cmp_tag] <= 1'b0;
            end
            if (enq) begin
                vld[free_idx]   <= 1'b1;
                iss[free_idx]   <= 1'b0;
                kind[free_idx]  <= enq_kind;
                addr[free_idx]  <= enq_addr;
                older[free_idx] <= '0;
                for (int j = 0; j < DEPTH; j++)
                    if (TW'(j) != free_idx)
                        older[j][free_idx] <= vld[j] && !(cmp_valid && cmp_tag == TW'(j));
            end
            if (snp_rsv_hit || (dc_acc && dop == D_STCOND && rsv_match))
                rsv_v <= 1'b0;
            if (dc_acc && dop == D_LDRSV) begin
                rsv_v    <= 1'b1;
                rsv_line <= dc_addr[AW-1:LINE_BITS];
            end
            if (dc_acc && dop == D_TOUCH) begin
                touch_valid <= 1'b1;
                touch_addr  <= dc_addr;
            end
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (&vld) |-> (!dc_ready && !ic_ready)); // R2
    AST_ARB_TIE: assert property (@(posedge clk) disable iff (rst)
        dc_valid |-> !ic_ready); // R1
    AST_ISSUE_PENDING: assert property (@(posedge clk) disable iff (rst)
        bus_valid |-> (vld[bus_tag] && !iss[bus_tag])); // R5
    AST_NO_REISSUE: assert property (@(posedge clk) disable iff (rst)
        (issue && !(cmp_valid && cmp_tag == grant_idx)) |=> iss[$past(grant_idx)]); // R5
    AST_STC_FAIL_SRC: assert property (@(posedge clk) disable iff (rst)
        stc_fail |-> $past(dc_valid && dc_op == 3'd5)); // R8
    AST_RSV_DROP: assert property (@(posedge clk) disable iff (rst)
        (snp_rsv_hit && !(dc_acc && dop == D_LDRSV)) |=> !rsv_v); // R7
    AST_TOUCH_SRC: assert property (@(posedge clk) disable iff (rst)
        $rose(touch_valid) |-> $past(dc_valid && dc_op == 3'd3)); // R9

endmodule

// File: tb/test_bus_req_queue.sv
module test_bus_req_queue;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ic_valid = 1'b0, dc_valid = 1'b0, bus_ready = 1'b0;
    logic        cmp_valid = 1'b0, snp_valid = 1'b0;
    logic [31:0] ic_addr = '0, dc_addr = '0, snp_addr = '0;
    logic [2:0]  dc_op = '0;
    logic [1:0]  cmp_tag = '0;
    logic        ic_ready, dc_ready, bus_valid, snp_rsv_hit, stc_fail, touch_valid;
    logic [1:0]  bus_op, bus_tag;
    logic [31:0] bus_addr, touch_addr;
    logic [3:0]  snp_hit;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    bus_req_queue i_bus_req_queue (
        .clk(clk), .rst(rst),
        .ic_valid(ic_valid), .ic_ready(ic_ready), .ic_addr(ic_addr),
        .dc_valid(dc_valid), .dc_ready(dc_ready), .dc_op(dc_op), .dc_addr(dc_addr),
        .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_op(bus_op),
        .bus_addr(bus_addr), .bus_tag(bus_tag),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag),
        .snp_valid(snp_valid), .snp_addr(snp_addr),
        .snp_hit(snp_hit), .snp_rsv_hit(snp_rsv_hit),
        .stc_fail(stc_fail), .touch_valid(touch_valid), .touch_addr(touch_addr)
    );

    // op, addr, expect failure, expected bus kind
    localparam logic [37:0] VEC [11] = '{
        {3'd5, 32'h0000_1000, 1'b1, 2'd0},
        {3'd4, 32'h0000_1000, 1'b0, 2'd1},
        {3'd5, 32'h0000_1008, 1'b0, 2'd2},
        {3'd5, 32'h0000_1000, 1'b1, 2'd0},
        {3'd0, 32'h0000_2000, 1'b0, 2'd1},
        {3'd1, 32'h0000_2040, 1'b0, 2'd2},
        {3'd2, 32'h0000_3000, 1'b0, 2'd3},
        {3'd3, 32'h0000_4444, 1'b0, 2'd1},
        {3'd4, 32'h0000_5000, 1'b0, 2'd1},
        {3'd5, 32'h0000_5020, 1'b1, 2'd0},
        {3'd5, 32'h0000_501F, 1'b0, 2'd2}
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic dc_put(input logic [2:0] op, input logic [31:0] a);
        dc_valid = 1'b1; dc_op = op; dc_addr = a;
        step();
        dc_valid = 1'b0;
    endtask

    task automatic ic_put(input logic [31:0] a);
        ic_valid = 1'b1; ic_addr = a;
        step();
        ic_valid = 1'b0;
    endtask

    task automatic issue_one(output logic [1:0] op, output logic [1:0] tag, output logic [31:0] a);
        bus_ready = 1'b1;
        #1;
        op = bus_op; tag = bus_tag; a = bus_addr;
        chk(bus_valid, "R5 issue available", 32'(bus_valid), 1);
        step();
        bus_ready = 1'b0;
    endtask

    task automatic complete(input logic [1:0] tag);
        cmp_valid = 1'b1; cmp_tag = tag;
        step();
        cmp_valid = 1'b0;
    endtask

    task automatic expect_issue(input logic [1:0] eop, input logic [1:0] etag, input string req);
        logic [1:0] op, tag;
        logic [31:0] a;
        issue_one(op, tag, a);
        chk(op == eop, req, 32'(op), 32'(eop));
        chk(tag == etag, req, 32'(tag), 32'(etag));
    endtask

    task automatic snoop(input logic [31:0] a);
        snp_valid = 1'b1; snp_addr = a;
        step();
        snp_valid = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [1:0] op, tag;
        logic [31:0] a;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        #1;
        // R10 reset state
        chk(dc_ready && ic_ready, "R10 ready after reset", {dc_ready, ic_ready}, 3);
        chk(!bus_valid && !stc_fail && !touch_valid, "R10 quiet outputs", {bus_valid, stc_fail, touch_valid}, 0);
        chk(snp_hit == 0 && !snp_rsv_hit, "R10 snoop quiet", 32'(snp_hit), 0);

        // Table walk: single requests through an empty queue (R8, R9, R7)
        foreach (VEC[k]) begin
            dc_put(VEC[k][37:35], VEC[k][34:3]);
            chk(stc_fail == VEC[k][2], "R8 conditional store status", 32'(stc_fail), 32'(VEC[k][2]));
            if (!VEC[k][2]) begin
                issue_one(op, tag, a);
                chk(op == VEC[k][1:0], "R9 bus kind", 32'(op), 32'(VEC[k][1:0]));
                chk(a == VEC[k][34:3], "R9 bus address", a, VEC[k][34:3]);
                chk(tag == 2'd0, "R2 lowest slot", 32'(tag), 0);
                complete(tag);
            end else begin
                #1 chk(!bus_valid, "R8 failed store stays off bus", 32'(bus_valid), 0);
            end
        end
        chk(touch_valid && touch_addr == 32'h4444, "R9 touch register", touch_addr, 32'h4444);

        // R1 tie between ports
        dc_valid = 1'b1; dc_op = 3'd1; dc_addr = 32'h100;
        ic_valid = 1'b1; ic_addr = 32'h300;
        #1 chk(!ic_ready && dc_ready, "R1 data port wins tie", {ic_ready, dc_ready}, 1);
        step();
        dc_valid = 1'b0;
        step();
        ic_valid = 1'b0;
        dc_put(3'd2, 32'h200);
        dc_put(3'd0, 32'h400);
        #1 chk(!dc_ready && !ic_ready, "R2 full queue stalls", {dc_ready, ic_ready}, 0);
        // store tag0, fetch tag1, castout tag2, load tag3 (R3)
        expect_issue(2'd1, 2'd3, "R3 load first");
        expect_issue(2'd0, 2'd1, "R3 fetch second");
        expect_issue(2'd2, 2'd0, "R3 store before later castout");
        expect_issue(2'd3, 2'd2, "R3 castout last");
        #1 chk(!bus_valid, "R5 no reissue", 32'(bus_valid), 0);
        complete(2'd2);
        #1 chk(dc_ready, "R5 out of order completion frees slot", 32'(dc_ready), 1);
        dc_put(3'd0, 32'h500);
        expect_issue(2'd1, 2'd2, "R2 freed slot reused");
        complete(2'd0); complete(2'd1); complete(2'd2); complete(2'd3);

        // R3 age beats slot number
        ic_put(32'h600);
        dc_put(3'd1, 32'h700);
        dc_put(3'd1, 32'h800);
        expect_issue(2'd0, 2'd0, "R3 fetch before stores");
        complete(2'd0);
        dc_put(3'd1, 32'h900);
        expect_issue(2'd2, 2'd1, "R3 oldest store first");
        expect_issue(2'd2, 2'd2, "R3 second oldest store");
        expect_issue(2'd2, 2'd0, "R3 newest store in low slot last");
        complete(2'd0); complete(2'd1); complete(2'd2);

        // R4 same-line hazard and different-line bypass
        dc_put(3'd1, 32'h100);
        dc_put(3'd0, 32'h11C);
        expect_issue(2'd2, 2'd0, "R4 store ahead of same-line load");
        expect_issue(2'd1, 2'd1, "R4 load after store");
        complete(2'd0); complete(2'd1);
        dc_put(3'd1, 32'h100);
        dc_put(3'd0, 32'h120);
        expect_issue(2'd1, 2'd1, "R4 other-line load bypasses");
        expect_issue(2'd2, 2'd0, "R4 store follows");
        complete(2'd0); complete(2'd1);

        // R6 / R7 snoop
        dc_put(3'd0, 32'h800);
        dc_put(3'd1, 32'h900);
        dc_put(3'd4, 32'hA00);
        snoop(32'h81F);
        chk(snp_hit == 4'b0001 && !snp_rsv_hit, "R6 slot hit", 32'(snp_hit), 32'h1);
        snoop(32'hB00);
        chk(snp_hit == 4'b0000, "R6 no hit", 32'(snp_hit), 0);
        snoop(32'hA04);
        chk(snp_hit == 4'b0100, "R6 reserved slot hit", 32'(snp_hit), 32'h4);
        chk(snp_rsv_hit, "R7 reservation hit", 32'(snp_rsv_hit), 1);
        step();
        chk(!snp_rsv_hit && snp_hit == 0, "R6 hit lasts one cycle", 32'(snp_hit), 0);
        dc_put(3'd5, 32'hA00);
        chk(stc_fail, "R7 cleared reservation fails store", 32'(stc_fail), 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule